// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block is the digital serial-interface controller of a 14-bit sampling converter. A host frames each transaction with an active-low chip select and clocks data out on a serial clock. The sequencer counts serial clock falling edges inside each frame and finishes a conversion on the 16th. It tracks whether the host uses short frames of 16 clocks or long frames of 32 clocks, and it shifts the result out MSB first. A parallel result input stands in for the analog core. That input is sampled at the moment chip select falls.

A chip-select rise before the 16th falling edge aborts the conversion. The next frame is flagged as carrying invalid data. A power-down enable pin is looked at only when chip select rises, and it powers the block down until the next frame begins. All inputs are taken as synchronous to the system clock `clk`, and edges on `cs_n` and `sclk` are found by comparing each input with its value one clock earlier.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, sdo_en, sdo, data_valid, converting, powered_down and mode32 are 0, and acquiring is 1.
- R2: A chip-select falling edge starts a conversion (converting = 1). The conversion ends on the 16th serial clock falling edge of the frame (converting = 0). Falling edges are counted only while chip select is low.
- R3: The serial word is 16 bits: the 14-bit result, MSB first, followed by two 0 bits. Its first bit appears on sdo after the chip-select falling edge, and each later bit follows a serial clock falling edge. In 16-clock mode, the first 16 bits carry the result of the previous completed conversion.
- R4: When chip select stays low past the 16th falling edge, the newly completed result is shifted out in the same 16-bit format, starting at the 16th falling edge. Bits after the 32nd edge are 0.
- R5: A frame that reaches its 30th falling edge sets mode32 = 1 on that edge. A frame that ends with 16 to 29 edges clears mode32 to 0. An aborted frame leaves mode32 unchanged.
- R6: While mode32 = 1 at the start of a frame, the first 16 bits of that frame are all 0.
- R7: If chip select rises before the 16th falling edge, no result is stored. In the following frame, data_valid is 0 from its chip-select fall until its 16th falling edge, and then becomes 1. The sample taken in that following frame is output in the frame after it. data_valid is also 0 in the first frame after reset.
- R8: pd_en is sampled only at the chip-select rising edge. powered_down then equals the sampled level and holds until the next chip-select falling edge, which clears it. pd_en has no effect at any other time.
- R9: sdo_en is 1 while chip select is low and 0 while it is high. sdo is 0 whenever sdo_en is 0.
- R10: acquiring is 1 exactly when neither converting nor powered_down is 1.
- R11: conv_data is captured at the chip-select falling edge. Changes to it later in the frame do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| sclk | input | 1 | Serial clock; its falling edges are counted |
| pd_en | input | 1 | Power-down request, sampled at the chip-select rise |
| conv_data | input | 14 | Parallel conversion result from the core model |
| sdo | output | 1 | Serial data, MSB first |
| sdo_en | output | 1 | Output enable for sdo (0 means high impedance) |
| data_valid | output | 1 | 1 when the current frame's data is a real result |
| converting | output | 1 | Conversion in progress |
| acquiring | output | 1 | Acquisition phase |
| powered_down | output | 1 | Power-down state active |
| mode32 | output | 1 | 32-clock framing detected |

## Verification
The bench aims at the exact edges where the framing rules switch.

- A long frame that stops at 30 edges still has to set mode32. A design that waited for the 32nd edge would instead send the previous result where zeros belong.
- A frame of 22 edges has to shift out new data from edge 16 while leaving the mode at 16 clocks. A design that decided the mode at edge 16 or 17 would be caught here.
- An 8-edge abort must drop data_valid only for the next frame. A design that stored the partial result, or kept the flag low one frame too long, would fail.
- conv_data is changed after the chip-select fall. This exposes a design that captures it at the 16th edge.
- pd_en is raised in the middle of a frame. This exposes a design that powers down on the level rather than at the chip-select rise.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  // counter wide enough to saturate above a 32-clock frame
  localparam int unsigned CNT_W = 6;
  typedef logic [CNT_W-1:0] edge_cnt_t;

  typedef enum logic {
    MODE_16 = 1'b0,
    MODE_32 = 1'b1
  } frame_mode_e;

  // true when the falling edge now being counted is the nth of the frame
  function automatic logic is_nth_edge(input edge_cnt_t cnt, input int unsigned n);
    return cnt == edge_cnt_t'(n - 1);
  endfunction

  // a frame ending after conversion but before the long-frame edge reverts to 16 clocks
  function automatic frame_mode_e mode_at_close(input frame_mode_e cur, input edge_cnt_t cnt,
                                                input int unsigned long_edge);
    return (cnt < edge_cnt_t'(long_edge)) ? MODE_16 : cur;
  endfunction
endpackage

// File: rtl/frame_edges.sv
`timescale 1ns/1ps
module frame_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall
);
  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  // only count edges inside an open frame
  assign sclk_fall = sclk_q & ~sclk & ~cs_q & ~cs_n;
endmodule

// File: rtl/frame_counter.sv
`timescale 1ns/1ps
module frame_counter
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_EDGE = 16,
  parameter int unsigned LONG_EDGE = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_fall,
  input  logic        cs_rise,
  input  logic        sclk_fall,
  input  logic        pd_en,
  output logic        conv_done,
  output logic        long_hit,
  output logic        abort_evt,
  output logic        abort_pend,
  output frame_mode_e mode,
  output logic        converting,
  output logic        powered_down,
  output logic        data_valid
);
  localparam edge_cnt_t CNT_MAX = '1;

  edge_cnt_t cnt;

  assign conv_done = sclk_fall & converting & is_nth_edge(cnt, CONV_EDGE);
  assign long_hit  = sclk_fall & is_nth_edge(cnt, LONG_EDGE);
  assign abort_evt = cs_rise & converting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      converting   <= 1'b0;
      powered_down <= 1'b0;
      abort_pend   <= 1'b1;
      data_valid   <= 1'b0;
      mode         <= MODE_16;
    end else begin
      if (cs_fall) begin
        cnt          <= '0;
        converting   <= 1'b1;
        powered_down <= 1'b0;
        data_valid   <= ~abort_pend;
      end else if (sclk_fall && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
      if (conv_done) begin
        converting <= 1'b0;
        abort_pend <= 1'b0;
        data_valid <= 1'b1;
      end
      if (long_hit) mode <= MODE_32;
      if (cs_rise) begin
        converting   <= 1'b0;
        powered_down <= pd_en;
        if (abort_evt) abort_pend <= 1'b1;
        else           mode <= mode_at_close(mode, cnt, LONG_EDGE);
      end
    end
  end
endmodule

// File: rtl/sdo_shifter.sv
`timescale 1ns/1ps
module sdo_shifter #(
  parameter int unsigned RES_W  = 14,
  parameter int unsigned SLOT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic             conv_done,
  input  logic             zero_lead,
  input  logic [RES_W-1:0] prev_res,
  input  logic [RES_W-1:0] new_res,
  output logic             sdo,
  output logic             sdo_en
);
  localparam int unsigned PAD_W = SLOT_W - RES_W;

  function automatic logic [SLOT_W-1:0] to_slot(input logic [RES_W-1:0] r);
    return {r, {PAD_W{1'b0}}};
  endfunction

  logic [SLOT_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sdo_en <= 1'b0;
    end else begin
      if (cs_fall) begin
        shreg  <= zero_lead ? '0 : to_slot(prev_res);
        sdo_en <= 1'b1;
      end else if (conv_done) begin
        shreg <= to_slot(new_res);
      end else if (sclk_fall) begin
        shreg <= {shreg[SLOT_W-2:0], 1'b0};
      end
      if (cs_rise) sdo_en <= 1'b0;
    end
  end

  assign sdo = sdo_en & shreg[SLOT_W-1];
endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W     = 14,
  parameter int unsigned SLOT_W    = 16,
  parameter int unsigned CONV_EDGE = 16,
  parameter int unsigned LONG_EDGE = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             pd_en,
  input  logic [RES_W-1:0] conv_data,
  output logic             sdo,
  output logic             sdo_en,
  output logic             data_valid,
  output logic             converting,
  output logic             acquiring,
  output logic             powered_down,
  output logic             mode32
);
  logic        cs_fall, cs_rise, sclk_fall;
  logic        conv_done, long_hit, abort_evt, abort_pend;
  frame_mode_e mode;
  logic [RES_W-1:0] sample_q, result_q;

  frame_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall)
  );

  frame_counter #(.CONV_EDGE(CONV_EDGE), .LONG_EDGE(LONG_EDGE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .pd_en(pd_en), .conv_done(conv_done),
    .long_hit(long_hit), .abort_evt(abort_evt), .abort_pend(abort_pend),
    .mode(mode), .converting(converting), .powered_down(powered_down),
    .data_valid(data_valid)
  );

  // sample at the frame start, commit when the conversion completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      result_q <= '0;
    end else begin
      if (cs_fall)   sample_q <= conv_data;
      if (conv_done) result_q <= sample_q;
    end
  end

  sdo_shifter #(.RES_W(RES_W), .SLOT_W(SLOT_W)) u_sdo (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .conv_done(conv_done),
    .zero_lead(mode == MODE_32), .prev_res(result_q), .new_res(sample_q),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  assign mode32    = (mode == MODE_32);
  assign acquiring = ~converting & ~powered_down;
endmodule

// File: rtl/adc_frame_seq_chk.sv
`timescale 1ns/1ps
module adc_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_en,
  input logic cs_fall,
  input logic cs_rise,
  input logic conv_done,
  input logic long_hit,
  input logic abort_evt,
  input logic abort_pend,
  input logic sdo_en,
  input logic converting,
  input logic powered_down,
  input logic mode32,
  input logic data_valid
);
  p_conv_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> converting);
  p_conv_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !converting);
  p_long_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    long_hit |=> mode32);
  p_abort_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> abort_pend);
  p_invalid_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && abort_pend) |=> !data_valid);
  p_pd_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (powered_down == $past(pd_en)));
  p_pd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_rise && !cs_fall) |=> $stable(powered_down));
  p_en_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo_en);
  p_en_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_en);
endmodule

bind adc_frame_seq adc_frame_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .conv_done(conv_done), .long_hit(long_hit), .abort_evt(abort_evt),
  .abort_pend(abort_pend), .sdo_en(sdo_en), .converting(converting),
  .powered_down(powered_down), .mode32(mode32), .data_valid(data_valid)
);

// File: tb/adc_frame_seq_tb.sv
`timescale 1ns/1ps
module adc_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        pd_en = 1'b0;
  logic [13:0] conv_data = '0;
  logic sdo, sdo_en, data_valid, converting, acquiring, powered_down, mode32;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [13:0] m_prev = '0;
  logic        m_long = 1'b0;
  logic        m_pend = 1'b1;

  always #5 clk = ~clk;

  adc_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .pd_en(pd_en),
    .conv_data(conv_data), .sdo(sdo), .sdo_en(sdo_en), .data_valid(data_valid),
    .converting(converting), .acquiring(acquiring), .powered_down(powered_down),
    .mode32(mode32)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one frame of nedge falling edges; checks serial data against the model
  task automatic do_frame(input int nedge, input logic [13:0] din,
                          input logic pd_mid, input logic pd_end);
    logic [31:0] cap, exp, mask;
    logic [15:0] lead;
    int nbits;
    cap = '0;
    lead = m_long ? 16'h0000 : {m_prev, 2'b00};
    conv_data = din;
    cs_n = 1'b0;
    step();
    conv_data = ~din;        // R11: late changes must not matter
    pd_en = pd_mid;
    cap[31] = sdo;
    check("R9 sdo_en low frame", {31'd0, sdo_en}, 32'd1);
    check("R7 data_valid at start", {31'd0, data_valid}, {31'd0, ~m_pend});
    check("R2 converting at start", {31'd0, converting}, 32'd1);
    for (int k = 1; k <= nedge; k++) begin
      sclk = 1'b1; step();
      sclk = 1'b0; step();
      if (k < 32) cap[31-k] = sdo;
      if (k == 15) check("R2 converting before 16th", {31'd0, converting}, 32'd1);
      if (k == 16) begin
        check("R2 converting after 16th", {31'd0, converting}, 32'd0);
        check("R7 data_valid after 16th", {31'd0, data_valid}, 32'd1);
      end
      if (k == 29) check("R5 mode before 30th", {31'd0, mode32}, {31'd0, m_long});
      if (k == 30) check("R5 mode at 30th", {31'd0, mode32}, 32'd1);
    end
    nbits = (nedge + 1 > 32) ? 32 : nedge + 1;
    mask = ~(32'hFFFF_FFFF >> nbits);
    exp = {lead, din, 2'b00} & mask;
    check(m_long ? "R6 zero lead bits" : "R3 lead bits",
          {16'd0, cap[31:16] & mask[31:16]}, {16'd0, exp[31:16]});
    if (nedge >= 16)
      check("R4 tail bits R11", {16'd0, cap[15:0] & mask[15:0]}, {16'd0, exp[15:0]});
    pd_en = pd_end;
    cs_n = 1'b1;
    step();
    pd_en = 1'b0;
    check("R9 sdo_en after rise", {30'd0, sdo_en, sdo}, 32'd0);
    check("R8 powered_down latch", {31'd0, powered_down}, {31'd0, pd_end});
    check("R10 acquiring", {31'd0, acquiring}, {31'd0, ~pd_end});
    if (nedge >= 16) begin
      m_prev = din;
      m_pend = 1'b0;
      m_long = (nedge >= 30);
    end else begin
      m_pend = 1'b1;
    end
    check("R5 mode after frame", {31'd0, mode32}, {31'd0, m_long});
    step(); step();
  endtask

  task automatic t_reset();
    check("R1 reset outputs",
          {26'd0, sdo_en, sdo, data_valid, converting, powered_down, mode32}, 32'd0);
    check("R1 reset acquiring", {31'd0, acquiring}, 32'd1);
  endtask

  task automatic t_short_frames();
    do_frame(16, 14'h2ABC, 1'b0, 1'b0);   // R7: first frame after reset invalid
    do_frame(16, 14'h1357, 1'b0, 1'b0);   // R3: previous result leads
    do_frame(16, 14'h3FFF, 1'b0, 1'b0);
  endtask

  task automatic t_long_tail();
    do_frame(22, 14'h0F0F, 1'b0, 1'b0);   // R4 tail, R5 stays short
    do_frame(16, 14'h00F1, 1'b0, 1'b0);
  endtask

  task automatic t_mode32();
    do_frame(32, 14'h3C5A, 1'b0, 1'b0);   // R5 long mode
    do_frame(30, 14'h1111, 1'b0, 1'b0);   // R6 zeros, clock stops at 30
    do_frame(17, 14'h2468, 1'b0, 1'b0);   // R6 zeros, then back to short
    do_frame(16, 14'h0ACE, 1'b0, 1'b0);   // R3 previous result again
  endtask

  task automatic t_abort();
    do_frame(8, 14'h1F00, 1'b0, 1'b0);    // R7 abort
    do_frame(16, 14'h0BAD, 1'b0, 1'b0);   // R7 invalid frame
    do_frame(16, 14'h0321, 1'b0, 1'b0);   // R7 sample of n+1 leads here
    do_frame(30, 14'h2222, 1'b0, 1'b0);
    do_frame(5, 14'h1234, 1'b0, 1'b0);    // R5 abort keeps long mode
    do_frame(16, 14'h3333, 1'b0, 1'b0);
  endtask

  task automatic t_power_down();
    do_frame(16, 14'h0777, 1'b0, 1'b1);   // R8 power down
    pd_en = 1'b1; step(); step();
    check("R8 pd_en ignored while high", {31'd0, powered_down}, 32'd1);
    pd_en = 1'b0;
    do_frame(16, 14'h1888, 1'b1, 1'b0);   // R8 mid-frame pd_en ignored
    check("R10 acquiring after resume", {31'd0, acquiring}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_short_frames();
    t_long_tail();
    t_mode32();
    t_abort();
    t_power_down();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule